// File: doc/BRIEF.md
# Interrupt-to-Message Controller

This block gathers a parameterised set of external interrupt lines (64 by default) and turns each one that needs service into a message. A message is an 8-bit vector number and an 8-bit route byte, handed to a downstream transport over a valid/ready handshake. Software configures the block through a simple 32-bit register bus. Per line it sets the trigger kind (edge or level) and the active sense (rising/high or falling/low). It can mask the line, enable conversion to a message, and program a vector byte and a route byte.

Raw inputs are first brought into the clock domain by two flops. An edge-mode line latches a sticky pending bit on its chosen edge. Software drops that bit with a write-one-to-clear register, and reading the same register shows the live pending bits. A level-mode line is pending for as long as its sense-adjusted input is active. Among lines that are pending, unmasked, enabled and not yet reported, the lowest-numbered one wins the next message. Each pending episode is reported once. A level line is reported again only after it goes inactive and active again, or after a mask/unmask cycle.

Line n sits in word n/32 at bit n%32 of every per-line bit register, and the second word sits 4 bytes above the first. Two general-purpose storage words per word-slot are kept for software and have no effect on behaviour.

Top module: `irqmsg_ctrl`

## Requirements
- R1: After synchronous reset every mask bit reads 1; the enable, trigger, sense, storage, route and vector registers read 0; the pending view reads 0; msg_valid is 0.
- R2: Word-aligned writes to the bit registers update only the bytes whose bus_be bit is set. Offsets are mask 0x20, enable 0x40, trigger 0x60, storage 0xC0 and 0xE0, and sense 0x3E0, each plus 4 for lines 32..63. A read returns the stored word on bus_rdata in the cycle after bus_rd and holds it until the next read.
- R3: The route byte of line n is at byte address 0x100+n and the vector byte at 0x200+n. Each is held in byte lane n%4 (bits 8*(n%4)+7 down to 8*(n%4)) of its word and written under that lane's bus_be bit.
- R4: A write to an unmapped or non-word-aligned address changes no register, and a read from one returns 0. Beyond 0x100+N-1 and 0x200+N-1 counts as unmapped.
- R5: A line whose trigger bit is 1 sets its pending bit on a rising input edge when its sense bit is 0, or on a falling edge when it is 1. The bit stays set after the input returns until a 1 is written to its bit at offset 0x80/0x84. Reading 0x80/0x84 returns the pending bits.
- R6: A line whose trigger bit is 0 is pending exactly while its input equals the inverse of its sense bit (high when sense is 0, low when sense is 1).
- R7: A message is issued only for a line that is pending, has mask bit 0 and enable bit 1. The message carries that line's vector byte on msg_vector and its route byte on msg_route.
- R8: When several lines qualify, messages leave in ascending line order.
- R9: While msg_valid is 1 and msg_ready is 0, msg_valid, msg_vector and msg_route hold their values.
- R10: Each pending episode produces one accepted message. A line that stays pending is not sent again until it leaves pending (level inactive, or edge cleared) or is masked and unmasked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for writes |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | NUM_LINES | Raw asynchronous interrupt lines |
| msg_ready | input | 1 | Downstream accepts the current message |
| msg_valid | output | 1 | A message is offered |
| msg_vector | output | 8 | Vector byte of the offered line |
| msg_route | output | 8 | Route byte of the offered line |

## Verification
The bench builds the block with NUM_LINES at 64 and ADDR_W at 12. With those values the second register word is present, so a line just above the word boundary (40) and the top line (63) can be placed there. The last lane of the route and vector arrays is reachable, and the first word past each array (0x140, 0x240) falls in the 12-bit space as an unmapped target. Random lines sets spread across both words check the ascending message order over the full width.

// File: rtl/irqmsg_pkg.sv
package irqmsg_pkg;
  // Word indices (byte offset / 4) of each register region.
  localparam int unsigned WOFF_MASK  = 8;    // 0x020
  localparam int unsigned WOFF_MSGEN = 16;   // 0x040
  localparam int unsigned WOFF_TRIG  = 24;   // 0x060
  localparam int unsigned WOFF_CLR   = 32;   // 0x080
  localparam int unsigned WOFF_BNC0  = 48;   // 0x0C0
  localparam int unsigned WOFF_BNC1  = 56;   // 0x0E0
  localparam int unsigned WOFF_ROUTE = 64;   // 0x100
  localparam int unsigned WOFF_VEC   = 128;  // 0x200
  localparam int unsigned WOFF_SENSE = 248;  // 0x3E0

  function automatic logic [31:0] lane_merge(input logic [31:0] old_w,
                                             input logic [31:0] new_w,
                                             input logic [3:0]  be);
    logic [31:0] r;
    for (int l = 0; l < 4; l++)
      r[8*l +: 8] = be[l] ? new_w[8*l +: 8] : old_w[8*l +: 8];
    return r;
  endfunction
endpackage

// File: rtl/irqmsg_regs.sv
module irqmsg_regs
  import irqmsg_pkg::*;
#(
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  input  logic [3:0]             bus_be,
  output logic [31:0]            bus_rdata,
  input  logic [NUM_LINES-1:0]   pend,
  output logic [NUM_LINES-1:0]   mask_o,
  output logic [NUM_LINES-1:0]   en_o,
  output logic [NUM_LINES-1:0]   trig_o,
  output logic [NUM_LINES-1:0]   sense_o,
  output logic [NUM_LINES-1:0]   clr_o,
  output logic [NUM_LINES*8-1:0] route_o,
  output logic [NUM_LINES*8-1:0] vec_o
);
  localparam int unsigned NW = NUM_LINES / 32;
  localparam int unsigned NQ = NUM_LINES / 4;
  localparam int unsigned WA = ADDR_W - 2;

  logic [WA-1:0] wa;
  logic          aligned, wr_ok;
  logic [31:0]   bmask, rd_val;
  logic [NUM_LINES-1:0]   mask_q, en_q, trig_q, sense_q, bnc0_q, bnc1_q;
  logic [NUM_LINES*8-1:0] route_q, vec_q;

  assign wa      = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_ok   = bus_wr & aligned;
  assign bmask   = {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      en_q    <= '0;
      trig_q  <= '0;
      sense_q <= '0;
      bnc0_q  <= '0;
      bnc1_q  <= '0;
    end else if (wr_ok) begin
      for (int w = 0; w < NW; w++) begin
        if (wa == WA'(WOFF_MASK + w))  mask_q[w*32 +: 32]  <= lane_merge(mask_q[w*32 +: 32], bus_wdata, bus_be);
        if (wa == WA'(WOFF_MSGEN + w)) en_q[w*32 +: 32]    <= lane_merge(en_q[w*32 +: 32], bus_wdata, bus_be);
        if (wa == WA'(WOFF_TRIG + w))  trig_q[w*32 +: 32]  <= lane_merge(trig_q[w*32 +: 32], bus_wdata, bus_be);
        if (wa == WA'(WOFF_SENSE + w)) sense_q[w*32 +: 32] <= lane_merge(sense_q[w*32 +: 32], bus_wdata, bus_be);
        if (wa == WA'(WOFF_BNC0 + w))  bnc0_q[w*32 +: 32]  <= lane_merge(bnc0_q[w*32 +: 32], bus_wdata, bus_be);
        if (wa == WA'(WOFF_BNC1 + w))  bnc1_q[w*32 +: 32]  <= lane_merge(bnc1_q[w*32 +: 32], bus_wdata, bus_be);
      end
    end
  end

  // Per-line byte arrays: four lines share one bus word.
  always_ff @(posedge clk) begin
    if (rst) begin
      route_q <= '0;
      vec_q   <= '0;
    end else if (wr_ok) begin
      for (int q = 0; q < NQ; q++) begin
        if (wa == WA'(WOFF_ROUTE + q)) route_q[q*32 +: 32] <= lane_merge(route_q[q*32 +: 32], bus_wdata, bus_be);
        if (wa == WA'(WOFF_VEC + q))   vec_q[q*32 +: 32]   <= lane_merge(vec_q[q*32 +: 32], bus_wdata, bus_be);
      end
    end
  end

  always_comb begin
    clr_o = '0;
    if (wr_ok)
      for (int w = 0; w < NW; w++)
        if (wa == WA'(WOFF_CLR + w)) clr_o[w*32 +: 32] = bus_wdata & bmask;
  end

  always_comb begin
    rd_val = '0;
    if (aligned) begin
      for (int w = 0; w < NW; w++) begin
        if (wa == WA'(WOFF_MASK + w))  rd_val = mask_q[w*32 +: 32];
        if (wa == WA'(WOFF_MSGEN + w)) rd_val = en_q[w*32 +: 32];
        if (wa == WA'(WOFF_TRIG + w))  rd_val = trig_q[w*32 +: 32];
        if (wa == WA'(WOFF_SENSE + w)) rd_val = sense_q[w*32 +: 32];
        if (wa == WA'(WOFF_BNC0 + w))  rd_val = bnc0_q[w*32 +: 32];
        if (wa == WA'(WOFF_BNC1 + w))  rd_val = bnc1_q[w*32 +: 32];
        if (wa == WA'(WOFF_CLR + w))   rd_val = pend[w*32 +: 32];
      end
      for (int q = 0; q < NQ; q++) begin
        if (wa == WA'(WOFF_ROUTE + q)) rd_val = route_q[q*32 +: 32];
        if (wa == WA'(WOFF_VEC + q))   rd_val = vec_q[q*32 +: 32];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  assign mask_o  = mask_q;
  assign en_o    = en_q;
  assign trig_o  = trig_q;
  assign sense_o = sense_q;
  assign route_o = route_q;
  assign vec_o   = vec_q;

  // R1
  mask_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_o == '1 && en_o == '0));
endmodule

// File: rtl/irqmsg_cond.sv
module irqmsg_cond #(
  parameter int unsigned NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic [NUM_LINES-1:0] trig,
  input  logic [NUM_LINES-1:0] sense,
  input  logic [NUM_LINES-1:0] clr,
  output logic [NUM_LINES-1:0] pend
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic s1, s2, act_q, pend_q;
    logic act, rise;

    assign act  = s2 ^ sense[i];
    assign rise = act & ~act_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        s1     <= 1'b0;
        s2     <= 1'b0;
        act_q  <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        s1     <= irq_in[i];
        s2     <= s1;
        act_q  <= act;
        pend_q <= trig[i] ? ((pend_q & ~clr[i]) | rise) : act;
      end
    end

    assign pend[i] = pend_q;

    // R5
    edge_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (trig[i] && pend_q && !clr[i]) |=> pend_q);
    // R5
    edge_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (trig[i] && clr[i] && !rise) |=> !pend_q);
  end
endmodule

// File: rtl/irqmsg_arb.sv
module irqmsg_arb #(
  parameter int unsigned NUM_LINES = 64
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_LINES-1:0]   pend,
  input  logic [NUM_LINES-1:0]   mask,
  input  logic [NUM_LINES-1:0]   en,
  input  logic [NUM_LINES*8-1:0] route_i,
  input  logic [NUM_LINES*8-1:0] vec_i,
  input  logic                   msg_ready,
  output logic                   msg_valid,
  output logic [7:0]             msg_vector,
  output logic [7:0]             msg_route
);
  localparam int unsigned IW = $clog2(NUM_LINES);

  logic [NUM_LINES-1:0] sent_q, elig, below;
  logic [IW-1:0]        pick, idx_q;
  logic                 any;

  assign elig = pend & ~mask & en & ~sent_q;
  assign any  = |elig;

  always_comb begin
    pick = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--)
      if (elig[i]) pick = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid  <= 1'b0;
      msg_vector <= '0;
      msg_route  <= '0;
      idx_q      <= '0;
      sent_q     <= '0;
    end else begin
      for (int i = 0; i < NUM_LINES; i++)
        if (!pend[i] || mask[i]) sent_q[i] <= 1'b0;
      if (msg_valid && msg_ready) begin
        msg_valid     <= 1'b0;
        sent_q[idx_q] <= 1'b1;
      end else if (!msg_valid && any) begin
        msg_valid  <= 1'b1;
        idx_q      <= pick;
        msg_vector <= vec_i[{pick, 3'b000} +: 8];
        msg_route  <= route_i[{pick, 3'b000} +: 8];
      end
    end
  end

  assign below = (NUM_LINES'(1) << idx_q) - NUM_LINES'(1);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_route)));
  // R8
  lowest_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> (($past(elig) & below) == '0));
  // R7
  winner_eligible_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> ((($past(elig) >> idx_q) & NUM_LINES'(1)) != '0));
endmodule

// File: rtl/irqmsg_ctrl.sv
module irqmsg_ctrl #(
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic [3:0]           bus_be,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 msg_ready,
  output logic                 msg_valid,
  output logic [7:0]           msg_vector,
  output logic [7:0]           msg_route
);
  logic [NUM_LINES-1:0]   mask, en, trig, sense, clr, pend;
  logic [NUM_LINES*8-1:0] route_b, vec_b;

  irqmsg_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata), .pend(pend),
    .mask_o(mask), .en_o(en), .trig_o(trig), .sense_o(sense), .clr_o(clr),
    .route_o(route_b), .vec_o(vec_b));

  irqmsg_cond #(.NUM_LINES(NUM_LINES)) u_cond (
    .clk(clk), .rst(rst), .irq_in(irq_in), .trig(trig), .sense(sense),
    .clr(clr), .pend(pend));

  irqmsg_arb #(.NUM_LINES(NUM_LINES)) u_arb (
    .clk(clk), .rst(rst), .pend(pend), .mask(mask), .en(en),
    .route_i(route_b), .vec_i(vec_b), .msg_ready(msg_ready),
    .msg_valid(msg_valid), .msg_vector(msg_vector), .msg_route(msg_route));
endmodule

// File: tb/sim_irqmsg_ctrl.sv
`timescale 1ns/1ps
module sim_irqmsg_ctrl;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] irq_in = '0;
  logic        msg_ready = 1'b0;
  logic        msg_valid;
  logic [7:0]  msg_vector, msg_route;

  irqmsg_ctrl #(.NUM_LINES(N), .ADDR_W(12)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .msg_ready(msg_ready), .msg_valid(msg_valid), .msg_vector(msg_vector),
    .msg_route(msg_route));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_mask[2], m_en[2], m_trig[2], m_sense[2], m_b0[2], m_b1[2];
  logic [7:0]  m_route[N], m_vec[N];
  logic [15:0] cap[256];
  int          cap_n = 0;

  always @(negedge clk) begin
    #1;
    if (!rst && msg_valid && msg_ready) begin
      if (cap_n < 256) cap[cap_n] = {msg_route, msg_vector};
      cap_n++;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] d, input logic [3:0] be);
    logic [31:0] r;
    for (int l = 0; l < 4; l++) r[8*l +: 8] = be[l] ? d[8*l +: 8] : o[8*l +: 8];
    return r;
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    int w;
    if (a[1:0] != 2'b00) return 32'h0;
    w = int'(a[11:2]);
    if (w == 8 || w == 9)     return m_mask[w-8];
    if (w == 16 || w == 17)   return m_en[w-16];
    if (w == 24 || w == 25)   return m_trig[w-24];
    if (w == 248 || w == 249) return m_sense[w-248];
    if (w == 48 || w == 49)   return m_b0[w-48];
    if (w == 56 || w == 57)   return m_b1[w-56];
    if (w >= 64 && w < 64 + N/4)
      return {m_route[4*(w-64)+3], m_route[4*(w-64)+2], m_route[4*(w-64)+1], m_route[4*(w-64)]};
    if (w >= 128 && w < 128 + N/4)
      return {m_vec[4*(w-128)+3], m_vec[4*(w-128)+2], m_vec[4*(w-128)+1], m_vec[4*(w-128)]};
    return 32'h0;
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
    int w;
    if (a[1:0] != 2'b00) return;
    w = int'(a[11:2]);
    if (w == 8 || w == 9)     m_mask[w-8]    = merge(m_mask[w-8], d, be);
    if (w == 16 || w == 17)   m_en[w-16]     = merge(m_en[w-16], d, be);
    if (w == 24 || w == 25)   m_trig[w-24]   = merge(m_trig[w-24], d, be);
    if (w == 248 || w == 249) m_sense[w-248] = merge(m_sense[w-248], d, be);
    if (w == 48 || w == 49)   m_b0[w-48]     = merge(m_b0[w-48], d, be);
    if (w == 56 || w == 57)   m_b1[w-56]     = merge(m_b1[w-56], d, be);
    for (int l = 0; l < 4; l++) if (be[l]) begin
      if (w >= 64 && w < 64 + N/4)   m_route[4*(w-64)+l] = d[8*l +: 8];
      if (w >= 128 && w < 128 + N/4) m_vec[4*(w-128)+l]  = d[8*l +: 8];
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_wr = 0; bus_rd = 0; irq_in = '0; msg_ready = 0;
    idle(3);
    rst = 1'b0;
    for (int w = 0; w < 2; w++) begin
      m_mask[w] = '1; m_en[w] = '0; m_trig[w] = '0; m_sense[w] = '0; m_b0[w] = '0; m_b1[w] = '0;
    end
    for (int n = 0; n < N; n++) begin m_route[n] = '0; m_vec[n] = '0; end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 0;
    model_write(a, d, be);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic accept();
    msg_ready = 1;
    @(negedge clk);
    msg_ready = 0;
  endtask

  task automatic set_byte(input logic [11:0] base, input int n, input logic [7:0] v);
    wr(base + 12'(4*(n/4)), {4{v}}, 4'(1 << (n % 4)));
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1..R10 act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [11:0] a;
    int unsigned dummy;
    logic [11:0] bases[6] = '{12'h020, 12'h040, 12'h060, 12'h3E0, 12'h0C0, 12'h0E0};
    logic [11:0] holes[9] = '{12'h000, 12'h004, 12'h0A0, 12'h140, 12'h240, 12'h300,
                              12'h3C0, 12'hFFC, 12'h022};
    logic [N-1:0] sets[4];
    dummy = $urandom(32'h5EED1);

    // R1 reset values
    do_reset();
    rd(12'h020, d); check("R1 mask w0", d, 32'hFFFF_FFFF);
    rd(12'h024, d); check("R1 mask w1", d, 32'hFFFF_FFFF);
    rd(12'h044, d); check("R1 enable w1", d, 0);
    rd(12'h060, d); check("R1 trigger w0", d, 0);
    rd(12'h3E4, d); check("R1 sense w1", d, 0);
    rd(12'h080, d); check("R1 pending w0", d, 0);
    rd(12'h23C, d); check("R1 vector last", d, 0);
    check("R1 msg_valid", 32'(msg_valid), 0);

    // R4 directed: unmapped write leaves mask untouched
    wr(12'h300, 32'h1234_5678, 4'hF);
    wr(12'h022, 32'h0, 4'hF);
    rd(12'h300, d); check("R4 unmapped read", d, 0);
    rd(12'h020, d); check("R4 mask unchanged by unaligned write", d, 32'hFFFF_FFFF);

    // R2/R3/R4 random register traffic against the model
    for (int k = 0; k < 300; k++) begin
      int r;
      r = $urandom_range(0, 8);
      if (r < 6)       a = bases[r] + 12'(4 * $urandom_range(0, 1));
      else if (r == 6) a = 12'h100 + 12'(4 * $urandom_range(0, N/4 - 1));
      else if (r == 7) a = 12'h200 + 12'(4 * $urandom_range(0, N/4 - 1));
      else             a = holes[$urandom_range(0, 8)];
      wr(a, $urandom, 4'($urandom_range(0, 15)));
      rd(a, d);
      if (r < 6)      check("R2 word register readback", d, exp_read(a));
      else if (r < 8) check("R3 byte array readback", d, exp_read(a));
      else            check("R4 unmapped readback", d, exp_read(a));
    end

    // R5 rising edge on line 5
    do_reset();
    wr(12'h040, 32'h20, 4'hF);
    wr(12'h060, 32'h20, 4'hF);
    set_byte(12'h200, 5, 8'h45);
    set_byte(12'h100, 5, 8'h01);
    wr(12'h080, 32'h20, 4'hF);
    wr(12'h020, ~32'h20, 4'hF);
    idle(6);
    check("R5 no message before edge", 32'(msg_valid), 0);
    irq_in[5] = 1; idle(3); irq_in[5] = 0; idle(8);
    rd(12'h080, d); check("R5 sticky pending bit5", d, 32'h20);
    check("R7 valid after edge", 32'(msg_valid), 1);
    check("R7 vector/route line5", {16'h0, msg_route, msg_vector}, 32'h0145);
    idle(5);
    check("R9 held while not ready", {15'h0, msg_valid, msg_route, msg_vector}, 32'h1_0145);
    accept(); idle(6);
    check("R10 no resend while pending", 32'(msg_valid), 0);
    wr(12'h080, 32'h20, 4'hF);
    rd(12'h080, d); check("R5 cleared by write-one", d, 0);
    irq_in[5] = 1; idle(3); irq_in[5] = 0; idle(8);
    check("R10 resend after clear and new edge", 32'(msg_valid), 1);
    accept();

    // R5 falling edge on line 40 (word 1 bit 8)
    do_reset();
    irq_in[40] = 1;
    wr(12'h064, 32'h100, 4'hF);
    wr(12'h3E4, 32'h100, 4'hF);
    wr(12'h044, 32'h100, 4'hF);
    set_byte(12'h200, 40, 8'h99);
    set_byte(12'h100, 40, 8'h07);
    idle(4);
    wr(12'h084, 32'h100, 4'hF);
    wr(12'h024, ~32'h100, 4'hF);
    idle(6);
    check("R5 falling-sense line high, no message", 32'(msg_valid), 0);
    irq_in[40] = 0; idle(8);
    check("R5 falling edge message", {15'h0, msg_valid, msg_route, msg_vector}, 32'h1_0799);
    accept();

    // R6 level-low on line 63
    do_reset();
    irq_in[63] = 1;
    wr(12'h3E4, 32'h8000_0000, 4'hF);
    wr(12'h044, 32'h8000_0000, 4'hF);
    set_byte(12'h200, 63, 8'hC3);
    set_byte(12'h100, 63, 8'h02);
    wr(12'h024, 32'h7FFF_FFFF, 4'hF);
    idle(6);
    rd(12'h084, d); check("R6 inactive high input not pending", d, 0);
    check("R6 no message while inactive", 32'(msg_valid), 0);
    irq_in[63] = 0; idle(6);
    rd(12'h084, d); check("R6 active low pending", d, 32'h8000_0000);
    check("R7 level message line63", {15'h0, msg_valid, msg_route, msg_vector}, 32'h1_02C3);
    accept(); idle(6);
    check("R10 level held, not resent", 32'(msg_valid), 0);
    wr(12'h024, 32'hFFFF_FFFF, 4'hF); idle(2);
    wr(12'h024, 32'h7FFF_FFFF, 4'hF); idle(4);
    check("R10 resent after mask/unmask", 32'(msg_valid), 1);
    accept();
    irq_in[63] = 1; idle(6);
    rd(12'h084, d); check("R6 pending drops when inactive", d, 0);
    check("R6 no message after release", 32'(msg_valid), 0);

    // R7 mask and enable gating on line 10
    do_reset();
    wr(12'h040, 32'h400, 4'hF);
    irq_in[10] = 1; idle(6);
    check("R7 masked line silent", 32'(msg_valid), 0);
    wr(12'h040, 32'h0, 4'hF);
    wr(12'h020, ~32'h400, 4'hF); idle(6);
    check("R7 disabled line silent", 32'(msg_valid), 0);
    wr(12'h040, 32'h400, 4'hF); idle(6);
    check("R7 enabled and unmasked fires", 32'(msg_valid), 1);

    // R8 ordering: one directed set plus random sets over both words
    sets[0] = (64'h1 << 3) | (64'h1 << 17) | (64'h1 << 33) | (64'h1 << 50);
    for (int s = 1; s < 4; s++) sets[s] = {$urandom, $urandom};
    for (int s = 0; s < 4; s++) begin
      int j;
      do_reset();
      for (int q = 0; q < N/4; q++) begin
        logic [31:0] vw, rw;
        for (int l = 0; l < 4; l++) begin
          vw[8*l +: 8] = 8'(8'h40 + 4*q + l);
          rw[8*l +: 8] = ~8'(4*q + l);
        end
        wr(12'h200 + 12'(4*q), vw, 4'hF);
        wr(12'h100 + 12'(4*q), rw, 4'hF);
      end
      wr(12'h040, 32'hFFFF_FFFF, 4'hF);
      wr(12'h044, 32'hFFFF_FFFF, 4'hF);
      wr(12'h020, 32'h0, 4'hF);
      wr(12'h024, 32'h0, 4'hF);
      cap_n = 0;
      msg_ready = 1;
      irq_in = sets[s];
      idle(220);
      msg_ready = 0;
      check("R10 one message per pending line", 32'(cap_n), 32'($countones(sets[s])));
      j = 0;
      for (int n = 0; n < N; n++) if (sets[s][n]) begin
        if (j < cap_n)
          check("R8 ascending order", 32'(cap[j]), {16'h0, ~8'(n), 8'(8'h40 + n)});
        j++;
      end
    end

    summary();
    $finish;
  end
endmodule